// File: doc/BRIEF.md
# Prioritised Interrupt Level Controller

This block collects up to 63 level-sensitive interrupt requests and forwards one request at a time to a processor core. The core receives a 3-bit request level and the number of the winning source. Software configures the block through a plain 32-bit register port. That port holds two things: a 64-bit mask split into two 32-bit words, and one control byte per source.

Each control byte packs an interrupt level and a priority within that level. Sources 1 to 7 are external lines whose control bytes are fixed in hardware. The other 56 sources are programmed freely. Source number 0 is reserved and never produces a request.

Every clock, the block looks at all requests that are pending, unmasked and configured. It picks the highest level among them. Within that level it picks the highest priority. If two candidates still tie, the lower source number wins. The result is registered.

The register port is a control path, not a stream. It has no valid/ready handshake and never applies back-pressure. A write takes effect at the clock edge on which the write enable is high. Read data is presented one cycle after the address is given.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the low mask word reads 0x00000001 and the high mask word reads 0x00000000. Every programmable control byte reads 0. The outputs are level 0 and source 0.
- R2: Word address 0 is the low mask word: bit n belongs to source n (n = 0..31). Word address 1 is the high mask word: bit n belongs to source 32+n. A mask bit of 1 blocks its source and a 0 lets it through.
- R3: Bit 0 of the low mask word is a block-all bit. While it is 1, no source wins, whatever the other mask bits hold. Any write to word address 0 with data bit 0 equal to 1 sets it.
- R4: Control bytes live at word addresses 16 to 31. Source 4*(a-16)+b uses bits [8b+5:8b] of word a. Within that byte, bits [5:3] are the level and bits [2:0] are the priority. Bits [8b+7:8b+6] are not stored and read as 0.
- R5: Sources 1 to 7 have fixed control bytes. Each reads back as level = source number and priority = 4. Writes to those bytes are ignored.
- R6: Source 0 is reserved. Its control byte reads 0, writes to it are ignored, and its pending input never produces a request.
- R7: A source is eligible only if it is pending, its mask bit is 0, block-all is 0, and its level field is non-zero. This covers both a control byte of 0 and a byte with level 0.
- R8: Among eligible sources, the highest level wins. Within that level, the highest priority wins. On an equal level and priority, the lower source number wins.
- R9: The level and source outputs are registered. After a rising edge, they reflect the pending inputs and register contents that were present just before that edge.
- R10: When no source is eligible, the level output is 0 and the source output is 0.
- R11: Read data is registered and appears one cycle after the address. Word addresses 2 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe for the register port |
| bus_addr | input | 5 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_pend | input | 64 | Level-sensitive requests, bit n = source n (bit 0 has no effect) |
| irq_level | output | 3 | Requested level toward the core, 0 = none |
| irq_src | output | 6 | Number of the winning source, 0 = none |

## Verification
The bench goes after the arbitration corners:
- Equal level and priority on several sources, where a design that scanned from the wrong end would report the higher number.
- A source with a non-zero priority but level 0, which a design testing the whole byte for zero would wrongly forward.
- Every source pending while block-all is set, where a design that treated bit 0 as an ordinary mask bit would still forward the others.

It also writes to the fixed and reserved control bytes. A design that stored those writes would then read back altered bytes and report wrong levels. Random traffic that mixes mask writes, control writes and request patterns exposes any output that updates a cycle early or late, or that uses the register values written at the same edge.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int LVL_W = 3;
  localparam int PRI_W = 3;
  localparam int CTL_W = LVL_W + PRI_W;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic [PRI_W-1:0] pri;
  } src_ctl_t;
endpackage

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import irq_prio_pkg::*;
#(
  parameter int NSRC      = 64,
  parameter int ADDR_W    = 5,
  parameter int NFIXED    = 7,
  parameter int FIXED_PRI = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  output logic [NSRC-1:0]       mask,
  output src_ctl_t [NSRC-1:0]   ctl
);
  localparam int NMW       = NSRC / 32;
  localparam int NCW       = NSRC / 4;
  localparam int CTRL_BASE = 1 << (ADDR_W - 1);

  logic [NSRC-1:0] mask_q;
  logic [31:0]     rd_mux;

  // Mask words: word 0 holds the block-all bit at position 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= NSRC'(1);
    end else if (wr_en) begin
      for (int w = 0; w < NMW; w++) begin
        if (addr == ADDR_W'(w)) mask_q[32*w +: 32] <= wdata;
      end
    end
  end
  assign mask = mask_q;

  // Per-source control bytes; reserved and fixed sources have no storage
  for (genvar s = 0; s < NSRC; s++) begin : g_ctl
    if (s == 0) begin : g_rsvd
      assign ctl[s] = '0;
    end else if (s <= NFIXED) begin : g_fixed
      assign ctl[s] = '{lvl: LVL_W'(s), pri: PRI_W'(FIXED_PRI)};
    end else begin : g_prog
      src_ctl_t ctl_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ctl_q <= '0;
        end else if (wr_en && addr == ADDR_W'(CTRL_BASE + s / 4)) begin
          ctl_q <= wdata[8*(s%4) +: CTL_W];
        end
      end
      assign ctl[s] = ctl_q;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < NMW; w++) begin
      if (addr == ADDR_W'(w)) rd_mux = mask_q[32*w +: 32];
    end
    for (int w = 0; w < NCW; w++) begin
      if (addr == ADDR_W'(CTRL_BASE + w)) begin
        for (int b = 0; b < 4; b++) begin
          rd_mux[8*b +: 8] = {{(8-CTL_W){1'b0}}, ctl[4*w+b]};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_mux;
  end

  a_r3_blockall_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0 && wdata[0]) |=> mask_q[0]);

  a_r2_high_word_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(1)) |=> (mask_q[63:32] == $past(wdata)));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
#(
  parameter int NSRC  = 64,
  parameter int SRC_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSRC-1:0]     pend,
  input  logic [NSRC-1:0]     mask,
  input  src_ctl_t [NSRC-1:0] ctl,
  output logic [LVL_W-1:0]    win_lvl,
  output logic [SRC_W-1:0]    win_src
);
  localparam int SC_W = CTL_W + SRC_W;

  logic [NSRC-1:0] elig;
  logic [NSRC-1:0] lvl_nz;
  logic [SC_W-1:0] node [1:2*NSRC-1];

  // Score = {level, priority, inverted number}: larger score wins,
  // the inverted number makes the lower source win a full tie.
  for (genvar s = 0; s < NSRC; s++) begin : g_leaf
    assign lvl_nz[s] = |ctl[s].lvl;
    assign node[NSRC+s] = elig[s] ? {ctl[s], ~SRC_W'(s)} : '0;
  end

  assign elig = pend & ~mask & lvl_nz & {NSRC{~mask[0]}} & ~NSRC'(1);

  for (genvar i = NSRC - 1; i >= 1; i--) begin : g_tree
    assign node[i] = (node[2*i] >= node[2*i+1]) ? node[2*i] : node[2*i+1];
  end

  always_comb begin
    if (node[1] == '0) begin
      win_lvl = '0;
      win_src = '0;
    end else begin
      win_lvl = node[1][SC_W-1 -: LVL_W];
      win_src = ~node[1][SRC_W-1:0];
    end
  end

  a_r7_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (win_src != '0) |-> (elig[win_src] && win_lvl == ctl[win_src].lvl));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NSRC      = 64,
  parameter int ADDR_W    = 5,
  parameter int NFIXED    = 7,
  parameter int FIXED_PRI = 4,
  localparam int SRC_W    = $clog2(NSRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr_en,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NSRC-1:0]    irq_pend,
  output logic [LVL_W-1:0]   irq_level,
  output logic [SRC_W-1:0]   irq_src
);
  logic [NSRC-1:0]     mask;
  src_ctl_t [NSRC-1:0] ctl;
  logic [LVL_W-1:0]    win_lvl;
  logic [SRC_W-1:0]    win_src;
  logic [NSRC-1:0]     pend_seen_q;

  irq_reg_file #(
    .NSRC(NSRC), .ADDR_W(ADDR_W), .NFIXED(NFIXED), .FIXED_PRI(FIXED_PRI)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .mask(mask), .ctl(ctl)
  );

  irq_arbiter #(.NSRC(NSRC), .SRC_W(SRC_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend(irq_pend), .mask(mask), .ctl(ctl),
    .win_lvl(win_lvl), .win_src(win_src)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_level   <= '0;
      irq_src     <= '0;
      pend_seen_q <= '0;
    end else begin
      irq_level   <= win_lvl;
      irq_src     <= win_src;
      pend_seen_q <= irq_pend;
    end
  end

  a_r10_idle_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == '0) == (irq_src == '0));

  a_r3_blockall_silences: assert property (@(posedge clk) disable iff (!rst_n)
    mask[0] |=> (irq_level == '0));

  a_r9_src_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_src != '0) |-> pend_seen_q[irq_src]);
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] irq_pend = '0;
  logic [2:0]  irq_level;
  logic [5:0]  irq_src;

  int n_chk = 0;
  int n_fail = 0;

  logic [63:0] sm;
  logic [5:0]  sc [64];

  always #5 clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pend(irq_pend),
    .irq_level(irq_level), .irq_src(irq_src)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic void model_reset();
    sm = 64'h1;
    for (int s = 0; s < 64; s++) sc[s] = '0;
    for (int s = 1; s <= 7; s++) sc[s] = {s[2:0], 3'd4};
  endfunction

  function automatic void model_write(input logic [4:0] a, input logic [31:0] d);
    if (a == 5'd0) sm[31:0] = d;
    else if (a == 5'd1) sm[63:32] = d;
    else if (a >= 5'd16) begin
      for (int b = 0; b < 4; b++) begin
        int s;
        s = 4 * (int'(a) - 16) + b;
        if (s > 7) sc[s] = d[8*b +: 6];
      end
    end
  endfunction

  function automatic logic [31:0] model_read(input logic [4:0] a);
    logic [31:0] r;
    r = '0;
    if (a == 5'd0) r = sm[31:0];
    else if (a == 5'd1) r = sm[63:32];
    else if (a >= 5'd16) begin
      for (int b = 0; b < 4; b++) r[8*b +: 8] = {2'b00, sc[4*(int'(a)-16)+b]};
    end
    return r;
  endfunction

  function automatic void model_win(input logic [63:0] p, output logic [2:0] l,
                                    output logic [5:0] w);
    logic [5:0] best;
    best = '0;
    l = '0;
    w = '0;
    for (int s = 1; s < 64; s++) begin
      if (p[s] && !sm[s] && !sm[0] && sc[s][5:3] != 3'd0) begin
        if (w == 6'd0 || sc[s] > best) begin
          best = sc[s];
          w = 6'(s);
          l = sc[s][5:3];
        end
      end
    end
  endfunction

  // Drive at a falling edge, check at the next falling edge
  task automatic step(input logic we, input logic [4:0] a, input logic [31:0] d,
                      input logic [63:0] p, input string req);
    logic [2:0]  el;
    logic [5:0]  es;
    logic [31:0] er;
    model_win(p, el, es);
    er = model_read(a);
    bus_wr_en = we;
    bus_addr  = a;
    bus_wdata = d;
    irq_pend  = p;
    if (we) model_write(a, d);
    @(negedge clk);
    bus_wr_en = 1'b0;
    chk(req, "level", 32'(irq_level), 32'(el));
    chk(req, "source", 32'(irq_src), 32'(es));
    chk(req, "rdata", bus_rdata, er);
  endtask

  initial begin
    #(10 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset level", 32'(irq_level), 0);
    chk("R10", "reset source", 32'(irq_src), 0);
    step(0, 5'd0, 0, '0, "R1 low mask");
    step(0, 5'd1, 0, '0, "R1 high mask");
    step(0, 5'd20, 0, '0, "R1 prog bytes");
    step(0, 5'd17, 0, '0, "R5 fixed read");
    chk("R5", "fixed word literal", bus_rdata, 32'h3C342C24);
    step(0, 5'd0, 0, '1, "R3 block-all with all pending");
    step(1, 5'd0, 32'h0, '1, "R3 clear block-all");
    step(0, 5'd0, 0, (64'h1 << 3) | (64'h1 << 5), "R8 fixed levels");
    chk("R8", "fixed 5 beats 3", 32'(irq_src), 5);
    step(1, 5'd18, 32'hFF2E2E2C, '0, "R4 program 8..11");
    step(0, 5'd18, 0, (64'h1 << 5) | (64'h1 << 8) | (64'h1 << 9) | (64'h1 << 10),
         "R8 tie at level 5");
    chk("R8", "tie lower number", 32'(irq_src), 9);
    chk("R4", "upper bits read 0", bus_rdata, 32'h3F2E2E2C);
    step(0, 5'd18, 0, (64'h1 << 5) | (64'h1 << 9) | (64'h1 << 11), "R8 level 7");
    chk("R8", "level 7 winner", 32'(irq_src), 11);
    step(1, 5'd19, 32'h00000007, '0, "R7 level0 byte");
    step(0, 5'd19, 0, 64'h1 << 12, "R7 level0 ignored");
    chk("R7", "idle level", 32'(irq_level), 0);
    step(0, 5'd0, 0, 64'h1, "R6 source 0 pending");
    chk("R6", "src0 no request", 32'(irq_src), 0);
    step(1, 5'd16, 32'hFFFFFFFF, '0, "R6 write reserved+fixed");
    step(0, 5'd16, 0, '0, "R5 fixed unchanged");
    chk("R5", "word 16 literal", bus_rdata, 32'h1C140C00);
    step(1, 5'd0, 32'h200, '0, "R2 mask source 9");
    step(0, 5'd0, 0, (64'h1 << 5) | (64'h1 << 8) | (64'h1 << 9) | (64'h1 << 10),
         "R2 masked 9");
    chk("R2", "10 wins", 32'(irq_src), 10);
    step(1, 5'd26, 32'h00000030, '0, "R4 program 40");
    step(0, 5'd26, 0, 64'h1 << 40, "R2 high word source");
    chk("R2", "40 wins", 32'(irq_src), 40);
    step(1, 5'd1, 32'h100, 64'h1 << 40, "R2 mask 40");
    step(0, 5'd1, 0, 64'h1 << 40, "R2 masked 40");
    chk("R2", "40 masked idle", 32'(irq_src), 0);
    step(1, 5'd0, 32'h1, (64'h1 << 5), "R3 write 1 low");
    step(0, 5'd0, 0, (64'h1 << 5), "R3 block-all set");
    chk("R3", "blocked", 32'(irq_level), 0);
    step(0, 5'd5, 0, '0, "R11 unmapped");
    for (int i = 0; i < 3000; i++) begin
      logic        we;
      logic [4:0]  a;
      logic [31:0] d;
      logic [63:0] p;
      we = ($urandom % 4) == 0;
      case ($urandom % 4)
        0: a = 5'd0;
        1: a = 5'd1;
        2: a = 5'($urandom);
        default: a = 5'(16 + ($urandom % 16));
      endcase
      d = $urandom;
      if (a == 5'd0) d[0] = ($urandom % 8) == 0;
      if (a <= 5'd1) d = d & $urandom;
      p = {$urandom, $urandom} & {$urandom, $urandom};
      step(we, a, d, p, "R8 R9 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule